// File: doc/BRIEF.md
# Register/memory operand address unit

This block resolves the operand named by a decoded mode field (2 bits), register/memory field (3 bits) and width flag of a two-operand instruction. It holds eight 16-bit general registers in a small internal register file with one write port. For a request it either picks out a register operand, or it forms a 16-bit memory effective address from base and index registers plus an optional displacement. Segment addition, the memory access itself and instruction fetch belong to other blocks.

A request is presented for one cycle with `req_valid`. Exactly one cycle later `out_valid` pulses and the registered results appear. `out_is_reg` tells register mode from memory mode. In register mode the block returns the word register index, the byte-lane flag for 8-bit operands and the operand value. In memory mode it returns the effective address. All results hold their values until the next request.

Top module: `rm_addr_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low in every other cycle.
- R2: A request with mode 2'b11 is register mode: `out_is_reg`=1 and `out_addr`=0, and `req_disp` has no effect on any output.
- R3: In register mode with `req_wide`=1, `out_reg_idx` equals the 3-bit code, `out_hi_byte`=0 and `out_value` is the full word register of that index (0 AX, 1 CX, 2 DX, 3 BX, 4 SP, 5 BP, 6 SI, 7 DI).
- R4: In register mode with `req_wide`=0, codes 0-3 give `out_reg_idx`=code, `out_hi_byte`=0 and bits [7:0] of that register; codes 4-7 give `out_reg_idx`=code-4, `out_hi_byte`=1 and bits [15:8] of that register; the upper 8 bits of `out_value` are zero.
- R5: In memory mode, code 0 gives BX+SI, code 1 BX+DI, code 2 BP+SI and code 3 BP+DI, each plus the displacement of the mode.
- R6: In memory mode, code 4 gives SI, code 5 DI and code 7 BX, each plus the displacement of the mode.
- R7: Code 6 gives BP plus displacement for modes 2'b01 and 2'b10, and with mode 2'b00 gives `req_disp` alone as a direct address.
- R8: Mode 2'b00 adds no displacement (except R7), mode 2'b01 adds `req_disp[7:0]` sign-extended with `req_disp[15:8]` ignored, mode 2'b10 adds all of `req_disp`; address sums wrap modulo 2^16.
- R9: In memory mode `out_is_reg`=0, `out_reg_idx`=0, `out_hi_byte`=0 and `out_value`=0.
- R10: With `wr_en` high, `wr_data` is stored into register `wr_idx` at the clock edge; a request in the same cycle still sees the previous contents.
- R11: While `rst_n` is low all outputs and all eight registers are zero.
- R12: In a cycle without `req_valid`, all result outputs other than `out_valid` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index to write |
| wr_data | input | 16 | Word to write |
| req_valid | input | 1 | Request strobe |
| req_mod | input | 2 | Mode field |
| req_rm | input | 3 | Register/memory field |
| req_wide | input | 1 | 1 word operand, 0 byte operand |
| req_disp | input | 16 | Displacement (low byte used for mode 2'b01) |
| out_valid | output | 1 | Result valid pulse |
| out_is_reg | output | 1 | 1 register mode, 0 memory mode |
| out_reg_idx | output | 3 | Word register index of the operand |
| out_hi_byte | output | 1 | Byte operand is the upper half |
| out_value | output | 16 | Register operand value |
| out_addr | output | 16 | Memory effective address |

## Verification
The bench builds the block with its default 16-bit data width, so the address wrap at 2^16 and the sign extension of the 8-bit displacement from bit 7 are both exercised at their real boundaries. A register holding 16'hFFF0 plus a positive displacement reaches the wrap, and a short displacement with bit 7 set and unrelated upper bits shows both the extension and the ignored upper byte. Every mode and code combination is swept against a behavioural model, followed by a run of random requests interleaved with writes, including writes in the same cycle as a request.

// File: rtl/rm_addr_pkg.sv
package rm_addr_pkg;

  localparam int CODE_W = 3;
  localparam int NUM_GPR = 8;

  localparam logic [1:0] MODE_NODISP = 2'b00;
  localparam logic [1:0] MODE_DISP8  = 2'b01;
  localparam logic [1:0] MODE_DISP16 = 2'b10;
  localparam logic [1:0] MODE_REG    = 2'b11;

  localparam logic [CODE_W-1:0] GPR_BX = 3'd3;
  localparam logic [CODE_W-1:0] GPR_BP = 3'd5;
  localparam logic [CODE_W-1:0] GPR_SI = 3'd6;
  localparam logic [CODE_W-1:0] GPR_DI = 3'd7;

  // How an effective address is put together
  typedef struct packed {
    logic              use_base;
    logic [CODE_W-1:0] base_sel;
    logic              use_index;
    logic [CODE_W-1:0] index_sel;
    logic              use_disp;
    logic              short_disp;
  } ea_plan_t;

endpackage

// File: rtl/gpr_file.sv
module gpr_file
  import rm_addr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = NUM_GPR,
  parameter int NUM_RD   = 3,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [NUM_RD-1:0][IDX_W-1:0]   rd_idx,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data
);

  logic [NUM_REGS-1:0][DATA_W-1:0] mem_q;
  logic [NUM_REGS-1:0][DATA_W-1:0] mem_d;
  logic [NUM_REGS-1:0]             mem_ce;

  for (genvar e = 0; e < NUM_REGS; e++) begin : g_entry
    always_comb begin
      mem_ce[e] = wr_en && (wr_idx == IDX_W'(e));
      mem_d[e]  = mem_ce[e] ? wr_data : mem_q[e];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[e] <= '0;
      end else if (mem_ce[e]) begin
        mem_q[e] <= mem_d[e];
      end
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rd_data[p] = mem_q[rd_idx[p]];
  end

endmodule

// File: rtl/ea_decode.sv
module ea_decode
  import rm_addr_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic [CODE_W-1:0] rm,
  output ea_plan_t          plan
);

  logic direct_addr;

  always_comb begin
    direct_addr = (mode == MODE_NODISP) && (rm == 3'b110);
    plan = '0;
    unique case (rm)
      3'b000: begin plan.use_base = 1'b1; plan.base_sel = GPR_BX;
                    plan.use_index = 1'b1; plan.index_sel = GPR_SI; end
      3'b001: begin plan.use_base = 1'b1; plan.base_sel = GPR_BX;
                    plan.use_index = 1'b1; plan.index_sel = GPR_DI; end
      3'b010: begin plan.use_base = 1'b1; plan.base_sel = GPR_BP;
                    plan.use_index = 1'b1; plan.index_sel = GPR_SI; end
      3'b011: begin plan.use_base = 1'b1; plan.base_sel = GPR_BP;
                    plan.use_index = 1'b1; plan.index_sel = GPR_DI; end
      3'b100: begin plan.use_index = 1'b1; plan.index_sel = GPR_SI; end
      3'b101: begin plan.use_index = 1'b1; plan.index_sel = GPR_DI; end
      3'b110: begin plan.use_base = !direct_addr; plan.base_sel = GPR_BP; end
      default: begin plan.use_base = 1'b1; plan.base_sel = GPR_BX; end
    endcase
    plan.use_disp   = (mode == MODE_DISP8) || (mode == MODE_DISP16) || direct_addr;
    plan.short_disp = (mode == MODE_DISP8);
  end

endmodule

// File: rtl/ea_adder.sv
module ea_adder
  import rm_addr_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int SHORT_W = 8
) (
  input  ea_plan_t          plan,
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] index_val,
  input  logic [DATA_W-1:0] disp,
  output logic [DATA_W-1:0] addr
);

  logic [DATA_W-1:0] disp_ext;
  logic [DATA_W-1:0] base_term;
  logic [DATA_W-1:0] index_term;
  logic [DATA_W-1:0] disp_term;

  always_comb begin
    disp_ext   = plan.short_disp
               ? {{(DATA_W-SHORT_W){disp[SHORT_W-1]}}, disp[SHORT_W-1:0]}
               : disp;
    base_term  = plan.use_base  ? base_val  : '0;
    index_term = plan.use_index ? index_val : '0;
    disp_term  = plan.use_disp  ? disp_ext  : '0;
    addr       = base_term + index_term + disp_term;
  end

endmodule

// File: rtl/opnd_sel.sv
module opnd_sel
  import rm_addr_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [CODE_W-1:0] rm,
  input  logic              wide,
  input  logic [DATA_W-1:0] reg_val,
  output logic [CODE_W-1:0] reg_idx,
  output logic              hi_byte,
  output logic [DATA_W-1:0] value
);

  always_comb begin
    hi_byte = !wide && rm[CODE_W-1];
    reg_idx = hi_byte ? {1'b0, rm[CODE_W-2:0]} : rm;
    if (wide) begin
      value = reg_val;
    end else if (hi_byte) begin
      value = {{HALF_W{1'b0}}, reg_val[DATA_W-1:HALF_W]};
    end else begin
      value = {{HALF_W{1'b0}}, reg_val[HALF_W-1:0]};
    end
  end

endmodule

// File: rtl/rm_addr_unit.sv
module rm_addr_unit
  import rm_addr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req_valid,
  input  logic [1:0]        req_mod,
  input  logic [2:0]        req_rm,
  input  logic              req_wide,
  input  logic [DATA_W-1:0] req_disp,
  output logic              out_valid,
  output logic              out_is_reg,
  output logic [2:0]        out_reg_idx,
  output logic              out_hi_byte,
  output logic [DATA_W-1:0] out_value,
  output logic [DATA_W-1:0] out_addr
);

  localparam int RD_BASE = 0;
  localparam int RD_INDEX = 1;
  localparam int RD_OPND = 2;
  localparam int NUM_RD = 3;

  ea_plan_t                         plan;
  logic [NUM_RD-1:0][CODE_W-1:0]    rd_idx;
  logic [NUM_RD-1:0][DATA_W-1:0]    rd_data;
  logic [DATA_W-1:0]                ea_addr;
  logic [CODE_W-1:0]                sel_idx;
  logic                             sel_hi;
  logic [DATA_W-1:0]                sel_value;
  logic                             is_reg_mode;

  ea_decode u_decode (
    .mode (req_mod),
    .rm   (req_rm),
    .plan (plan)
  );

  always_comb begin
    rd_idx[RD_BASE]  = plan.base_sel;
    rd_idx[RD_INDEX] = plan.index_sel;
    rd_idx[RD_OPND]  = sel_idx;
  end

  gpr_file #(.DATA_W(DATA_W), .NUM_REGS(NUM_GPR), .NUM_RD(NUM_RD)) u_gpr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  ea_adder #(.DATA_W(DATA_W)) u_adder (
    .plan      (plan),
    .base_val  (rd_data[RD_BASE]),
    .index_val (rd_data[RD_INDEX]),
    .disp      (req_disp),
    .addr      (ea_addr)
  );

  opnd_sel #(.DATA_W(DATA_W)) u_opnd (
    .rm      (req_rm),
    .wide    (req_wide),
    .reg_val (rd_data[RD_OPND]),
    .reg_idx (sel_idx),
    .hi_byte (sel_hi),
    .value   (sel_value)
  );

  // Next-state logic for the result registers
  logic              valid_d;
  logic              res_ce;
  logic              is_reg_d;
  logic [2:0]        reg_idx_d;
  logic              hi_byte_d;
  logic [DATA_W-1:0] value_d;
  logic [DATA_W-1:0] addr_d;

  always_comb begin
    is_reg_mode = (req_mod == MODE_REG);
    valid_d     = req_valid;
    res_ce      = req_valid;
    is_reg_d    = is_reg_mode;
    reg_idx_d   = is_reg_mode ? sel_idx   : '0;
    hi_byte_d   = is_reg_mode ? sel_hi    : 1'b0;
    value_d     = is_reg_mode ? sel_value : '0;
    addr_d      = is_reg_mode ? '0        : ea_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_is_reg  <= 1'b0;
      out_reg_idx <= '0;
      out_hi_byte <= 1'b0;
      out_value   <= '0;
      out_addr    <= '0;
    end else if (res_ce) begin
      out_is_reg  <= is_reg_d;
      out_reg_idx <= reg_idx_d;
      out_hi_byte <= hi_byte_d;
      out_value   <= value_d;
      out_addr    <= addr_d;
    end
  end

endmodule

// File: rtl/rm_addr_unit_chk.sv
module rm_addr_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_mod,
  input logic [2:0]        req_rm,
  input logic              req_wide,
  input logic [DATA_W-1:0] req_disp,
  input logic              out_valid,
  input logic              out_is_reg,
  input logic [2:0]        out_reg_idx,
  input logic              out_hi_byte,
  input logic [DATA_W-1:0] out_value,
  input logic [DATA_W-1:0] out_addr
);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  assert_valid_only_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  assert_reg_mode_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mod == 2'b11) |=> (out_is_reg && out_addr == '0));

  assert_byte_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mod == 2'b11 && !req_wide) |=> (out_value[DATA_W-1:DATA_W/2] == '0));

  assert_hi_lane_low_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_hi_byte |-> (out_is_reg && !out_reg_idx[2]));

  assert_direct_address_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mod == 2'b00 && req_rm == 3'b110) |=> (out_addr == $past(req_disp)));

  assert_mem_mode_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_reg) |-> (out_value == '0 && out_reg_idx == '0 && !out_hi_byte));

  assert_hold_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(out_addr) && $stable(out_value) && $stable(out_is_reg)
                    && $stable(out_reg_idx) && $stable(out_hi_byte)));

endmodule

bind rm_addr_unit rm_addr_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_mod     (req_mod),
  .req_rm      (req_rm),
  .req_wide    (req_wide),
  .req_disp    (req_disp),
  .out_valid   (out_valid),
  .out_is_reg  (out_is_reg),
  .out_reg_idx (out_reg_idx),
  .out_hi_byte (out_hi_byte),
  .out_value   (out_value),
  .out_addr    (out_addr)
);

// File: tb/rm_addr_unit_tb_top.sv
module rm_addr_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [15:0] wr_data;
  logic        req_valid;
  logic [1:0]  req_mod;
  logic [2:0]  req_rm;
  logic        req_wide;
  logic [15:0] req_disp;
  logic        out_valid;
  logic        out_is_reg;
  logic [2:0]  out_reg_idx;
  logic        out_hi_byte;
  logic [15:0] out_value;
  logic [15:0] out_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference state
  int mdl_reg [8];
  int e_valid, e_is_reg, e_idx, e_hi, e_value, e_addr;

  rm_addr_unit dut_i (
    .clk (clk), .rst_n (rst_n),
    .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data),
    .req_valid (req_valid), .req_mod (req_mod), .req_rm (req_rm),
    .req_wide (req_wide), .req_disp (req_disp),
    .out_valid (out_valid), .out_is_reg (out_is_reg), .out_reg_idx (out_reg_idx),
    .out_hi_byte (out_hi_byte), .out_value (out_value), .out_addr (out_addr)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "out_valid",   int'(out_valid),   e_valid);
    chk(tag, "out_is_reg",  int'(out_is_reg),  e_is_reg);
    chk(tag, "out_reg_idx", int'(out_reg_idx), e_idx);
    chk(tag, "out_hi_byte", int'(out_hi_byte), e_hi);
    chk(tag, "out_value",   int'(out_value),   e_value);
    chk(tag, "out_addr",    int'(out_addr),    e_addr);
  endtask

  function automatic int sext8(input int b);
    return (b >= 128) ? b - 256 : b;
  endfunction

  task automatic model_req(input int md, input int rm, input int w, input int dp);
    int base, idx, d;
    if (md == 3) begin
      e_is_reg = 1; e_addr = 0;
      if (w == 1) begin
        e_idx = rm; e_hi = 0; e_value = mdl_reg[rm];
      end else if (rm < 4) begin
        e_idx = rm; e_hi = 0; e_value = mdl_reg[rm] % 256;
      end else begin
        e_idx = rm - 4; e_hi = 1; e_value = mdl_reg[rm - 4] / 256;
      end
    end else begin
      // 3 BX, 5 BP, 6 SI, 7 DI
      case (rm)
        0: begin base = mdl_reg[3]; idx = mdl_reg[6]; end
        1: begin base = mdl_reg[3]; idx = mdl_reg[7]; end
        2: begin base = mdl_reg[5]; idx = mdl_reg[6]; end
        3: begin base = mdl_reg[5]; idx = mdl_reg[7]; end
        4: begin base = 0;          idx = mdl_reg[6]; end
        5: begin base = 0;          idx = mdl_reg[7]; end
        6: begin base = (md == 0) ? 0 : mdl_reg[5]; idx = 0; end
        default: begin base = mdl_reg[3]; idx = 0; end
      endcase
      if (md == 1)                d = sext8(dp % 256);
      else if (md == 2)           d = dp;
      else if (rm == 6)           d = dp;
      else                        d = 0;
      e_addr = (base + idx + d + 65536 * 4) % 65536;
      e_is_reg = 0; e_idx = 0; e_hi = 0; e_value = 0;
    end
  endtask

  // One clock: drive at the falling edge, check at the next falling edge
  task automatic step(input bit rq, input int md, input int rm, input int w, input int dp,
                      input bit we, input int wi, input int wd, input string tag);
    req_valid = rq; req_mod = 2'(md); req_rm = 3'(rm); req_wide = w[0]; req_disp = 16'(dp);
    wr_en = we; wr_idx = 3'(wi); wr_data = 16'(wd);
    e_valid = rq ? 1 : 0;
    if (rq) model_req(md, rm, w, dp);
    if (we) mdl_reg[wi] = wd;
    @(posedge clk);
    @(negedge clk);
    chk_all(tag);
  endtask

  task automatic req(input int md, input int rm, input int w, input int dp, input string tag);
    step(1, md, rm, w, dp, 0, 0, 0, tag);
  endtask

  task automatic wr(input int wi, input int wd, input string tag);
    step(0, 0, 0, 0, 0, 1, wi, wd, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    rst_n = 0;
    wr_en = 0; wr_idx = 0; wr_data = 0;
    req_valid = 0; req_mod = 0; req_rm = 0; req_wide = 0; req_disp = 0;
    for (int i = 0; i < 8; i++) mdl_reg[i] = 0;
    e_valid = 0; e_is_reg = 0; e_idx = 0; e_hi = 0; e_value = 0; e_addr = 0;
    repeat (3) @(negedge clk);
    chk_all("R11");
    @(negedge clk);
    rst_n = 1;

    // R11: registers read back as zero after reset
    for (int r = 0; r < 8; r++) req(3, r, 1, 0, "R11");

    // R10 / R12: writes without requests leave results unchanged
    wr(0, 16'hA1B2, "R10"); wr(1, 16'hC3D4, "R10"); wr(2, 16'h5E6F, "R10");
    wr(3, 16'h1000, "R10"); wr(4, 16'h7788, "R10"); wr(5, 16'h2000, "R10");
    wr(6, 16'h0030, "R10"); wr(7, 16'h0004, "R10");

    // R3: word registers
    for (int r = 0; r < 8; r++) req(3, r, 1, 16'h1234, "R3");
    // R4: byte registers, low and high halves
    for (int r = 0; r < 8; r++) req(3, r, 0, 16'hFFFF, "R4");
    // R2: displacement has no effect in register mode
    req(3, 5, 1, 16'hBEEF, "R2");

    // R5/R6/R7/R8/R9: every memory-mode code in every displacement mode
    for (int md = 0; md < 3; md++) begin
      for (int rm = 0; rm < 8; rm++) begin
        if (rm < 4)       tag = "R5";
        else if (rm == 6) tag = "R7";
        else              tag = "R6";
        req(md, rm, rm % 2, 16'h1280, tag);
        req(md, rm, 1, 16'h00F0, "R8");
      end
    end
    req(1, 4, 1, 16'hAB7F, "R8");
    req(0, 6, 0, 16'hCAFE, "R7");

    // R8: wrap modulo 2^16
    wr(3, 16'hFFF0, "R10");
    req(2, 7, 1, 16'h0020, "R8");
    req(1, 0, 1, 16'h0040, "R8");
    wr(5, 16'h0005, "R10");
    req(1, 2, 1, 16'h0080, "R8");

    // R10: write in the same cycle as a request is not seen by it
    step(1, 3, 0, 1, 0, 1, 0, 16'h5555, "R10");
    req(3, 0, 1, 0, "R10");
    step(1, 2, 4, 1, 16'h0100, 1, 6, 16'h0F00, "R10");
    req(2, 4, 1, 16'h0100, "R10");

    // R1 / R12: idle cycles with changing inputs
    for (int k = 0; k < 4; k++) step(0, k % 4, 7 - k, k % 2, 16'h3C3C + k, 0, 0, 0, "R1/R12");
    req(3, 6, 0, 0, "R1");
    step(0, 0, 6, 1, 16'h9999, 0, 0, 0, "R1/R12");

    // Mixed random traffic
    for (int n = 0; n < 600; n++) begin
      step(($urandom % 3) != 0, int'($urandom % 4), int'($urandom % 8), int'($urandom % 2),
           int'($urandom % 65536), ($urandom % 3) == 0, int'($urandom % 8),
           int'($urandom % 65536), "mixed");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule